// File: doc/BRIEF.md
# Register-Versus-Zero Branch Resolver

This block decides, in the execute stage, whether a branch that tests one 64-bit source register against zero is taken. It takes the register value, a 3-bit condition code and a handful of instruction qualifiers. It drives a taken strobe in the same cycle and a registered copy one stage later. The later copy also tells a conditional move whether it may complete.

Timing drives the structure. The wide all-zero reduction over the register arrives late. For that reason the condition is worked out twice from the narrow inputs: once as if the register were zero and once as if it were not. The zero flag only steers the final two-way select. The sign bit is cheap and is used directly. A condition-code based branch or move turns the register evaluation off, and its own externally computed outcome is OR-ed in. Unconditional jumps and calls are always taken. An annulled, invalid or killed instruction is never taken. An annulled valid instruction also raises a write-back kill.

Top module: `reg_zero_branch`

## Requirements
- R1: Condition code 3'b001 (equal zero) is taken exactly when all 64 bits of the register are zero.
- R2: Condition code 3'b101 (not zero) is taken exactly when at least one register bit is set.
- R3: Condition code 3'b011 (less than zero) is taken exactly when bit 63 is set. Condition code 3'b111 (greater or equal zero) is taken exactly when bit 63 is clear.
- R4: Condition code 3'b010 (less or equal zero) is taken when the register is zero or bit 63 is set. Condition code 3'b110 (greater than zero) is taken when the register is nonzero and bit 63 is clear.
- R5: The reserved condition codes 3'b000 and 3'b100 never produce a taken result from the register test.
- R6: With ccMode high, the register test is ignored. A conditional branch is then taken exactly when ccTaken is high. With ccMode low, ccTaken is still OR-ed into the conditional result.
- R7: A valid, unannulled, unkilled instruction with isJump or isCall high is taken whatever the register value and condition code.
- R8: An annulled instruction is never taken. wbKillE equals instValid AND instAnnul.
- R9: takenE is low whenever instValid is low or instKill is high.
- R10: takenM equals takenE of the previous clock cycle. A synchronous active-high reset clears takenM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| regValue | input | 64 | Source register value |
| cond | input | 3 | Register condition code |
| instValid | input | 1 | Execute-stage instruction is valid |
| instKill | input | 1 | Execute-stage instruction is killed |
| instAnnul | input | 1 | Execute-stage instruction is annulled |
| isCondBranch | input | 1 | Instruction is a conditional branch or move |
| ccMode | input | 1 | Condition comes from condition codes, not the register |
| ccTaken | input | 1 | Outcome of the condition-code evaluation |
| isJump | input | 1 | Unconditional branch |
| isCall | input | 1 | Call |
| takenE | output | 1 | Taken, execute stage |
| takenM | output | 1 | Registered taken, next stage; move-succeeded flag |
| wbKillE | output | 1 | Kill write-back and bypass of an annulled instruction |

## Verification
The hardest case to reach is the zero detect failing on a single set bit far from bit 0 while the precomputed paths disagree. That situation shows up only when the register holds one lone bit in an upper chunk, or only bit 63. The stimulus therefore sweeps every condition code against zero, a single low bit, a single bit in a middle chunk, bit 63 alone, all ones and the largest positive value. Each qualifier is then forced against inputs that would otherwise be taken.

// File: rtl/rzb_pkg.sv
package rzb_pkg;
  typedef struct packed {
    logic takeIfZero;     // outcome assuming register == 0
    logic takeIfNonZero;  // outcome assuming register != 0
    logic condBranch;     // outcome depends on the zero select
    logic forceTaken;     // jump or call
    logic blocked;        // annulled
  } rzbStrobes_t;
endpackage

// File: rtl/rzbCondCtrl.sv
module rzbCondCtrl
  import rzb_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [2:0]  cond,
  input  logic        negFlag,
  input  logic        isCondBranch,
  input  logic        ccMode,
  input  logic        ccTaken,
  input  logic        isJump,
  input  logic        isCall,
  input  logic        instAnnul,
  output rzbStrobes_t strobes
);
  logic legalCode;
  logic evalZero, evalNonZero;

  assign legalCode = |cond[1:0];

  // Both outcomes are ready before the zero reduction settles.
  always_comb begin
    if (negFlag) evalZero = ~cond[2];
    else         evalZero = (cond[1] & cond[0]) ^ ~cond[2];
    if (negFlag) evalNonZero = cond[1] ^ cond[2];
    else         evalNonZero = cond[2];
  end

  always_comb begin
    strobes.takeIfZero    = (evalZero    & legalCode & ~ccMode) | ccTaken;
    strobes.takeIfNonZero = (evalNonZero & legalCode & ~ccMode) | ccTaken;
    strobes.condBranch    = isCondBranch;
    strobes.forceTaken    = isJump | isCall;
    strobes.blocked       = instAnnul;
  end

  assert_cc_mode_R6: assert property (@(posedge clk) disable iff (rst)
    (ccMode && !ccTaken) |-> (!strobes.takeIfZero && !strobes.takeIfNonZero));
  assert_reserved_code_R5: assert property (@(posedge clk) disable iff (rst)
    (cond[1:0] == 2'b00 && !ccTaken) |-> (!strobes.takeIfZero && !strobes.takeIfNonZero));
endmodule

// File: rtl/rzbFlagPath.sv
module rzbFlagPath
  import rzb_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int CHUNK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] regValue,
  input  logic              instValid,
  input  logic              instKill,
  input  rzbStrobes_t       strobes,
  output logic              negFlag,
  output logic              takenE,
  output logic              takenM
);
  localparam int NUM_CHUNKS = (DATA_W + CHUNK_W - 1) / CHUNK_W;
  localparam int PAD_W      = NUM_CHUNKS * CHUNK_W;

  logic [PAD_W-1:0]      padded;
  logic [NUM_CHUNKS-1:0] chunkAny;
  logic                  zeroFlag;
  logic                  selected;
  logic                  rawTaken;

  assign padded  = PAD_W'(regValue);
  assign negFlag = regValue[DATA_W-1];

  generate
    for (genvar g = 0; g < NUM_CHUNKS; g++) begin : gChunk
      assign chunkAny[g] = |padded[g*CHUNK_W +: CHUNK_W];
    end
  endgenerate

  assign zeroFlag = ~|chunkAny;

  // Late zero flag only picks between the precomputed outcomes.
  assign selected = zeroFlag ? strobes.takeIfZero : strobes.takeIfNonZero;
  assign rawTaken = ((strobes.condBranch & selected) | strobes.forceTaken) & ~strobes.blocked;
  assign takenE   = rawTaken & instValid & ~instKill;

  always_ff @(posedge clk) begin
    if (rst) takenM <= 1'b0;
    else     takenM <= takenE;
  end

  assert_annul_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    strobes.blocked |-> !takenE);
  assert_qualify_R9: assert property (@(posedge clk) disable iff (rst)
    (!instValid || instKill) |-> !takenE);
  assert_force_taken_R7: assert property (@(posedge clk) disable iff (rst)
    (instValid && !instKill && !strobes.blocked && strobes.forceTaken) |-> takenE);
  assert_invalid_clears_next_R10: assert property (@(posedge clk) disable iff (rst)
    !instValid |=> !takenM);
endmodule

// File: rtl/reg_zero_branch.sv
module reg_zero_branch
  import rzb_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [63:0] regValue,
  input  logic [2:0]  cond,
  input  logic        instValid,
  input  logic        instKill,
  input  logic        instAnnul,
  input  logic        isCondBranch,
  input  logic        ccMode,
  input  logic        ccTaken,
  input  logic        isJump,
  input  logic        isCall,
  output logic        takenE,
  output logic        takenM,
  output logic        wbKillE
);
  rzbStrobes_t strobes;
  logic        negFlag;

  rzbCondCtrl uCtrl (
    .clk(clk), .rst(rst), .cond(cond), .negFlag(negFlag),
    .isCondBranch(isCondBranch), .ccMode(ccMode), .ccTaken(ccTaken),
    .isJump(isJump), .isCall(isCall), .instAnnul(instAnnul),
    .strobes(strobes)
  );

  rzbFlagPath #(.DATA_W(64), .CHUNK_W(8)) uPath (
    .clk(clk), .rst(rst), .regValue(regValue), .instValid(instValid),
    .instKill(instKill), .strobes(strobes), .negFlag(negFlag),
    .takenE(takenE), .takenM(takenM)
  );

  assign wbKillE = instValid & instAnnul;
endmodule

// File: tb/tb_reg_zero_branch.sv
module tb_reg_zero_branch;
  logic        clk = 0;
  logic        rst;
  logic [63:0] regValue;
  logic [2:0]  cond;
  logic instValid, instKill, instAnnul, isCondBranch, ccMode, ccTaken, isJump, isCall;
  logic takenE, takenM, wbKillE;
  int   nRun = 0, nFail = 0;
  logic done = 0;

  always #5 clk = ~clk;

  reg_zero_branch dut (.*);

  function automatic logic condModel(input logic [2:0] c, input logic [63:0] v);
    logic z, n;
    z = (v == 64'd0);
    n = v[63];
    case (c)
      3'b001: return z;
      3'b101: return !z;
      3'b011: return n;
      3'b111: return !n;
      3'b010: return z || n;
      3'b110: return !z && !n;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Drive at negedge, check takenE now and takenM after the next edge.
  task automatic apply(input string req, input logic [63:0] v, input logic [2:0] c,
                       input logic vld, input logic kil, input logic ann,
                       input logic cb, input logic ccm, input logic cct,
                       input logic jmp, input logic cal);
    logic exp;
    @(negedge clk);
    regValue = v; cond = c; instValid = vld; instKill = kil; instAnnul = ann;
    isCondBranch = cb; ccMode = ccm; ccTaken = cct; isJump = jmp; isCall = cal;
    exp = vld && !kil && !ann &&
          (jmp || cal || (cb && ((!ccm && condModel(c, v)) || cct)));
    #1;
    check(req, takenE, exp);
    check({req, " wbKill R8"}, wbKillE, vld && ann);
    @(negedge clk);
    check({req, " next stage R10"}, takenM, exp);
  endtask

  task automatic testReset;
    @(negedge clk);
    instValid = 1; isJump = 1;
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    check("reset clears takenM R10", takenM, 1'b0);
    rst = 0;
    instValid = 0; isJump = 0;
  endtask

  task automatic testConditions;
    logic [63:0] vals [6];
    vals[0] = 64'd0;
    vals[1] = 64'd1;
    vals[2] = 64'h0000_0100_0000_0000;
    vals[3] = 64'h8000_0000_0000_0000;
    vals[4] = '1;
    vals[5] = 64'h7fff_ffff_ffff_ffff;
    for (int c = 0; c < 8; c++)
      for (int i = 0; i < 6; i++) begin
        string tag;
        case (c)
          1: tag = "R1 eq-zero";
          5: tag = "R2 not-zero";
          3, 7: tag = "R3 sign";
          2, 6: tag = "R4 le/gt";
          default: tag = "R5 reserved";
        endcase
        apply(tag, vals[i], 3'(c), 1, 0, 0, 1, 0, 0, 0, 0);
      end
  endtask

  task automatic testCcMode;
    apply("R6 ccMode masks register", 64'd0, 3'b001, 1, 0, 0, 1, 1, 0, 0, 0);
    apply("R6 ccMode uses ccTaken", 64'd5, 3'b001, 1, 0, 0, 1, 1, 1, 0, 0);
    apply("R6 ccTaken OR-ed", 64'd5, 3'b001, 1, 0, 0, 1, 0, 1, 0, 0);
  endtask

  task automatic testForced;
    apply("R7 jump", 64'd7, 3'b000, 1, 0, 0, 0, 0, 0, 1, 0);
    apply("R7 call", 64'd0, 3'b101, 1, 0, 0, 1, 1, 0, 0, 1);
  endtask

  task automatic testQualifiers;
    apply("R8 annul", 64'd0, 3'b001, 1, 0, 1, 1, 0, 0, 1, 0);
    apply("R9 invalid", 64'd0, 3'b001, 0, 0, 0, 1, 0, 0, 1, 0);
    apply("R9 killed", 64'd0, 3'b001, 1, 1, 0, 1, 0, 0, 0, 1);
    apply("R10 taken after kill", 64'd0, 3'b001, 1, 0, 0, 1, 0, 0, 0, 0);
  endtask

  initial begin
    #100000;
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    rst = 1; regValue = 0; cond = 0; instValid = 0; instKill = 0; instAnnul = 0;
    isCondBranch = 0; ccMode = 0; ccTaken = 0; isJump = 0; isCall = 0;
    repeat (3) @(negedge clk);
    check("reset state R10", takenM, 1'b0);
    rst = 0;
    testConditions();
    testCcMode();
    testForced();
    testQualifiers();
    testReset();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule